// File: doc/BRIEF.md
# Bus Tenure State Machine

This controller sits inside a processor that shares an external bus with other masters. On every clock it decides who holds the bus. The processor may hold it implicitly, meaning it is granted but idle, or explicitly, meaning it is granted and driving transfers. It may also be winding down its own tenure. Otherwise another master holds it, either implicitly or explicitly. In that case the processor may briefly snoop that master's transfer. If another master starts driving while this processor still believes it is granted, the controller enters a sticky violation state that only reset clears.

The controller samples the grant, the external busy line, the transfer-start line, a snoop request qualified by a transfer-type bit, the core's own bus request, and the local transfer-progress and end-of-cycle indications. It registers the core request onto the request pin. It also applies two rules for locked sequences. The first adds an extra clock of tenure wind-down. The second keeps the bus through a locked run when lock release is not enabled.

Top module: `bus_tenure_fsm`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is Reset (state code 0), and `bus_req_o`, `snoop_en` and `violation` are low.
- R2: At the first edge with `rst` low in Reset, the next state is Implicit Own (code 1) if `grant` is high, and Alternate Implicit (code 4) otherwise.
- R3: `bus_req_o` equals the value `int_req` had at the previous clock edge.
- R4: In Alternate Implicit (4) or Alternate Explicit (5), the transitions are checked in this order:
  - An accepted snoop (`snoop_req` high and `tt1` low) goes to Snoop (6). A snoop with `tt1` high is ignored.
  - Otherwise, `busy_in` high goes to Alternate Explicit.
  - Otherwise, `grant` high goes to Explicit Own (2) when `int_req` is high, and to Implicit Own when it is low.
  - Otherwise, the next state is Alternate Implicit.
- R5: In Implicit Own, the transitions are checked in this order:
  - `grant` high together with `xfer_start` or `busy_in` high goes to Violation (7).
  - Otherwise, `grant` low goes to Alternate Implicit.
  - Otherwise, `int_req` high goes to Explicit Own.
  - Otherwise, the state stays Implicit Own.
- R6: Explicit Own stays while `grant` is high. With `grant` low it moves to End Tenure (code 3) when `xfer_busy` is low or `cycle_end` is high, and stays otherwise.
- R7: In End Tenure, the transitions are checked in this order:
  - `grant` high with `xfer_start` or `busy_in` high goes to Violation.
  - Otherwise, `grant` low goes to Alternate Implicit.
  - Otherwise, the next state is Explicit Own or Implicit Own, following `int_req`.
- R8: Snoop lasts exactly one clock and always leads to Alternate Explicit. `snoop_en` is high exactly in Snoop, so it is never high in two consecutive clocks.
- R9: Violation holds until reset, and `violation` is high in every clock spent there.
- R10: If `locked` is high on the edge that moves Explicit Own to End Tenure, or on the edge before it, End Tenure lasts one extra clock. The violation check of R7 still takes precedence during that clock.
- R11: While `locked` is high and `release_en` is low, a low `grant` does not end Explicit Own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| grant | input | 1 | Bus grant from the arbiter |
| busy_in | input | 1 | Sampled external bus-busy line |
| xfer_start | input | 1 | Sampled transfer-start line |
| snoop_req | input | 1 | Snoop request from the system |
| tt1 | input | 1 | Transfer-type bit qualifying a snoop |
| int_req | input | 1 | Core's internal bus request |
| xfer_busy | input | 1 | Own transfer in progress |
| cycle_end | input | 1 | Own transfer terminates this clock (normal, error or retry) |
| locked | input | 1 | A locked sequence is active |
| release_en | input | 1 | Allows release of the bus during a locked sequence |
| bus_req_o | output | 1 | Registered bus request pin |
| own_state | output | 3 | Ownership state code |
| snoop_en | output | 1 | Snoop strobe, one clock |
| violation | output | 1 | Protocol violation flag |

## Verification
The hardest state to reach is the extra wind-down clock of a locked tenure. The bench must first win explicit ownership and then hold it with `locked` high and `release_en` low while the grant is withdrawn. It then drops `locked` on the very clock it lets the tenure end, so that only the delayed lock sample triggers the extra clock. Directed sequences walk through this path, back-to-back snoops and each violation entry. A long random phase with periodic resets then compares every clock against a behavioural model.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_RESET   = 3'd0,
    ST_IMP_OWN = 3'd1,
    ST_EXP_OWN = 3'd2,
    ST_END_TEN = 3'd3,
    ST_ALT_IMP = 3'd4,
    ST_ALT_EXP = 3'd5,
    ST_SNOOP   = 3'd6,
    ST_VIOL    = 3'd7
  } bt_state_e;

  // snoop is taken only for the qualifying transfer type
  function automatic logic snoop_hit(input logic req, input logic tt);
    return req & ~tt;
  endfunction

  // another master shows activity while we hold the grant
  function automatic logic foreign_seen(input logic gnt, input logic ts, input logic bsy);
    return gnt & (ts | bsy);
  endfunction

  // which ownership flavour a fresh grant yields
  function automatic bt_state_e own_pick(input logic want);
    return want ? ST_EXP_OWN : ST_IMP_OWN;
  endfunction

  // own tenure may end once no transfer is left hanging
  function automatic logic tenure_can_end(input logic busy_own, input logic ending);
    return ~busy_own | ending;
  endfunction
endpackage

// File: rtl/bt_req_reg.sv
module bt_req_reg (
  input  logic clk,
  input  logic rst,
  input  logic int_req,
  output logic bus_req_o
);
  always_ff @(posedge clk) begin
    if (rst) bus_req_o <= 1'b0;
    else     bus_req_o <= int_req;
  end
endmodule

// File: rtl/bt_lock_track.sv
module bt_lock_track (
  input  logic clk,
  input  logic rst,
  input  logic locked,
  input  logic tenure_drop,
  input  logic in_end_ten,
  output logic extra_pend
);
  logic lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q     <= 1'b0;
      extra_pend <= 1'b0;
    end else begin
      lock_q <= locked;
      if (tenure_drop && (locked || lock_q)) extra_pend <= 1'b1;
      else if (in_end_ten)                   extra_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/bt_next.sv
module bt_next
  import bt_pkg::*;
(
  input  bt_state_e state,
  input  logic      grant,
  input  logic      busy_in,
  input  logic      xfer_start,
  input  logic      snoop_ok,
  input  logic      int_req,
  input  logic      xfer_busy,
  input  logic      cycle_end,
  input  logic      lock_hold,
  input  logic      extra_pend,
  output bt_state_e nxt
);
  logic intrude;
  assign intrude = foreign_seen(grant, xfer_start, busy_in);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RESET:   nxt = grant ? ST_IMP_OWN : ST_ALT_IMP;
      ST_IMP_OWN: begin
        if (intrude)      nxt = ST_VIOL;
        else if (!grant)  nxt = ST_ALT_IMP;
        else if (int_req) nxt = ST_EXP_OWN;
      end
      ST_EXP_OWN: begin
        if (!grant && !lock_hold && tenure_can_end(xfer_busy, cycle_end))
          nxt = ST_END_TEN;
      end
      ST_END_TEN: begin
        if (intrude)         nxt = ST_VIOL;
        else if (extra_pend) nxt = ST_END_TEN;
        else if (!grant)     nxt = ST_ALT_IMP;
        else                 nxt = own_pick(int_req);
      end
      ST_ALT_IMP, ST_ALT_EXP: begin
        if (snoop_ok)     nxt = ST_SNOOP;
        else if (busy_in) nxt = ST_ALT_EXP;
        else if (grant)   nxt = own_pick(int_req);
        else              nxt = ST_ALT_IMP;
      end
      ST_SNOOP:   nxt = ST_ALT_EXP;
      ST_VIOL:    nxt = ST_VIOL;
      default:    nxt = ST_RESET;
    endcase
  end
endmodule

// File: rtl/bus_tenure_fsm.sv
module bus_tenure_fsm
  import bt_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            grant,
  input  logic            busy_in,
  input  logic            xfer_start,
  input  logic            snoop_req,
  input  logic            tt1,
  input  logic            int_req,
  input  logic            xfer_busy,
  input  logic            cycle_end,
  input  logic            locked,
  input  logic            release_en,
  output logic            bus_req_o,
  output logic [ST_W-1:0] own_state,
  output logic            snoop_en,
  output logic            violation
);
  bt_state_e state, nxt;
  logic snoop_ok, lock_hold, tenure_drop, extra_pend;

  assign snoop_ok    = snoop_hit(snoop_req, tt1);
  assign lock_hold   = locked & ~release_en;
  assign tenure_drop = (state == ST_EXP_OWN) && (nxt == ST_END_TEN);

  bt_req_reg u_req (
    .clk(clk), .rst(rst), .int_req(int_req), .bus_req_o(bus_req_o)
  );

  bt_lock_track u_lock (
    .clk(clk), .rst(rst), .locked(locked), .tenure_drop(tenure_drop),
    .in_end_ten(state == ST_END_TEN), .extra_pend(extra_pend)
  );

  bt_next u_next (
    .state(state), .grant(grant), .busy_in(busy_in), .xfer_start(xfer_start),
    .snoop_ok(snoop_ok), .int_req(int_req), .xfer_busy(xfer_busy),
    .cycle_end(cycle_end), .lock_hold(lock_hold), .extra_pend(extra_pend),
    .nxt(nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RESET;
    else     state <= nxt;
  end

  assign own_state = state;
  assign snoop_en  = (state == ST_SNOOP);
  assign violation = (state == ST_VIOL);
endmodule

// File: rtl/bt_chk.sv
module bt_chk (
  input logic       clk,
  input logic       rst,
  input logic       grant,
  input logic       int_req,
  input logic       snoop_req,
  input logic       tt1,
  input logic       bus_req_o,
  input logic [2:0] own_state,
  input logic       snoop_en,
  input logic       violation
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= !rst;

  // R3
  br_copy_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> bus_req_o == $past(int_req));

  // R8
  snoop_gap_chk: assert property (@(posedge clk) disable iff (rst)
    snoop_en |=> !snoop_en);

  // R8
  snoop_exit_chk: assert property (@(posedge clk) disable iff (rst)
    snoop_en |=> own_state == 3'd5);

  // R4
  snoop_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && snoop_en) |-> ($past(snoop_req) && !$past(tt1)));

  // R9
  viol_hold_chk: assert property (@(posedge clk) disable iff (rst)
    violation |=> violation);

  // R5
  viol_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $rose(violation)) |->
      ($past(grant) && ($past(own_state) == 3'd1 || $past(own_state) == 3'd3)));
endmodule

bind bus_tenure_fsm bt_chk u_chk (
  .clk(clk), .rst(rst), .grant(grant), .int_req(int_req),
  .snoop_req(snoop_req), .tt1(tt1), .bus_req_o(bus_req_o),
  .own_state(own_state), .snoop_en(snoop_en), .violation(violation)
);

// File: tb/sim_bus_tenure_fsm.sv
module sim_bus_tenure_fsm;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic grant = 0, busy_in = 0, xfer_start = 0, snoop_req = 0, tt1 = 0;
  logic int_req = 0, xfer_busy = 0, cycle_end = 0, locked = 0, release_en = 1;
  logic bus_req_o, snoop_en, violation;
  logic [2:0] own_state;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  bus_tenure_fsm u0 (
    .clk(clk), .rst(rst), .grant(grant), .busy_in(busy_in),
    .xfer_start(xfer_start), .snoop_req(snoop_req), .tt1(tt1),
    .int_req(int_req), .xfer_busy(xfer_busy), .cycle_end(cycle_end),
    .locked(locked), .release_en(release_en), .bus_req_o(bus_req_o),
    .own_state(own_state), .snoop_en(snoop_en), .violation(violation)
  );

  // behavioural reference
  int m_st = 0;
  int m_br = 0;
  int m_lockq = 0;
  int m_extra = 0;
  int m_prev = 0;

  function automatic string tag_of(int s);
    case (s)
      0: return "R2";  1: return "R5";  2: return "R6";  3: return "R7";
      4: return "R4";  5: return "R4";  6: return "R8";  default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    int n;
    m_prev = m_st;
    if (rst) begin
      m_st = 0; m_br = 0; m_lockq = 0; m_extra = 0;
    end else begin
      n = m_st;
      if (m_st == 0) n = grant ? 1 : 4;
      else if (m_st == 1) begin
        if (grant && (xfer_start || busy_in)) n = 7;
        else if (!grant) n = 4;
        else if (int_req) n = 2;
      end else if (m_st == 2) begin
        if (!grant && !(locked && !release_en) && (!xfer_busy || cycle_end)) n = 3;
      end else if (m_st == 3) begin
        if (grant && (xfer_start || busy_in)) n = 7;
        else if (m_extra != 0) n = 3;
        else if (!grant) n = 4;
        else n = int_req ? 2 : 1;
      end else if (m_st == 4 || m_st == 5) begin
        if (snoop_req && !tt1) n = 6;
        else if (busy_in) n = 5;
        else if (grant) n = int_req ? 2 : 1;
        else n = 4;
      end else if (m_st == 6) n = 5;
      else n = 7;
      if (m_st == 2 && n == 3 && (locked || m_lockq != 0)) m_extra = 1;
      else if (m_st == 3) m_extra = 0;
      m_lockq = locked;
      m_br = int_req;
      m_st = n;
    end
  end

  task automatic fail(string req, int act, int exp);
    errors++;
    $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      checks += 4;
      if (int'(own_state) != m_st) fail(rst ? "R1" : tag_of(m_prev), own_state, m_st);
      if (int'(bus_req_o) != m_br) fail("R3", bus_req_o, m_br);
      if (int'(snoop_en) != (m_st == 6)) fail("R8", snoop_en, m_st == 6);
      if (int'(violation) != (m_st == 7)) fail("R9", violation, m_st == 7);
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_st(int exp, string req);
    checks++;
    if (int'(own_state) != exp) fail(req, own_state, exp);
  endtask

  task automatic quiet();
    grant = 0; busy_in = 0; xfer_start = 0; snoop_req = 0; tt1 = 0;
    int_req = 0; xfer_busy = 0; cycle_end = 0; locked = 0; release_en = 1;
  endtask

  task automatic do_reset(logic g);
    rst = 1; quiet(); grant = g;
    step(); step();
    rst = 0;
    step();
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    quiet();
    step(); step();
    // R1: held in reset
    expect_st(0, "R1");
    checks++; if (bus_req_o !== 1'b0) fail("R1", bus_req_o, 0);
    grant = 1; rst = 0;
    step(); expect_st(1, "R2");
    do_reset(1'b0); expect_st(4, "R2");

    // explicit tenure and its end
    do_reset(1'b1);
    int_req = 1; step(); expect_st(2, "R5");
    checks++; if (bus_req_o !== 1'b1) fail("R3", bus_req_o, 1);
    grant = 0; xfer_busy = 1; step(); expect_st(2, "R6");
    cycle_end = 1; step(); expect_st(3, "R6");
    cycle_end = 0; xfer_busy = 0; step(); expect_st(4, "R7");

    // snoop acceptance
    snoop_req = 1; tt1 = 1; step(); expect_st(4, "R4");
    checks++; if (snoop_en !== 1'b0) fail("R4", snoop_en, 0);
    tt1 = 0; step(); expect_st(6, "R8");
    checks++; if (snoop_en !== 1'b1) fail("R8", snoop_en, 1);
    step(); expect_st(5, "R8");
    step(); expect_st(6, "R4");
    snoop_req = 0; step(); expect_st(5, "R8");
    busy_in = 1; step(); expect_st(5, "R4");
    busy_in = 0; step(); expect_st(4, "R4");
    grant = 1; int_req = 0; step(); expect_st(1, "R4");

    // violation from implicit ownership
    xfer_start = 1; step(); expect_st(7, "R5");
    grant = 0; xfer_start = 0; step(); step(); expect_st(7, "R9");
    checks++; if (violation !== 1'b1) fail("R9", violation, 1);
    rst = 1; step(); expect_st(0, "R1");

    // locked hold and extra wind-down clock
    do_reset(1'b1);
    int_req = 1; step(); expect_st(2, "R5");
    locked = 1; release_en = 0; grant = 0; step(); expect_st(2, "R11");
    step(); expect_st(2, "R11");
    locked = 0; step(); expect_st(3, "R6");
    step(); expect_st(3, "R10");
    step(); expect_st(4, "R10");

    // End Tenure: clean regrant and violation
    do_reset(1'b1);
    int_req = 1; step(); grant = 0; step(); expect_st(3, "R6");
    grant = 1; step(); expect_st(2, "R7");
    grant = 0; step(); expect_st(3, "R6");
    grant = 1; busy_in = 1; step(); expect_st(7, "R7");

    // random sweep against the model
    for (int i = 0; i < 4000; i++) begin
      rst        = (i % 37 == 0);
      grant      = ($urandom % 3) != 0;
      busy_in    = ($urandom % 5) == 0;
      xfer_start = ($urandom % 9) == 0;
      snoop_req  = ($urandom % 3) == 0;
      tt1        = ($urandom % 2) == 0;
      int_req    = ($urandom % 2) == 0;
      xfer_busy  = ($urandom % 2) == 0;
      cycle_end  = ($urandom % 3) == 0;
      locked     = ($urandom % 4) == 0;
      release_en = ($urandom % 2) == 0;
      step();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule